// File: doc/BRIEF.md
# Cascaded Wide Binary Up Counter

This block is a wide synchronous binary up counter assembled from identical narrow counter slices (8 bits each by default, four slices for 32 bits). Each slice is a small up counter with an active-low advance enable. Each slice also gives a combinational active-low "saturated" flag, which is low exactly while that slice holds all ones.

The enable of each slice is formed in parallel. It is the OR of the global active-low enable and the saturated flags of every lower-order slice. A slice therefore advances only on an edge where every slice below it is at all ones. On that same edge the lower slices roll over to zero, so their flags go high again and the upper slices return to hold. The enable path has a constant depth of one wide OR. It does not grow by one gate per slice, so the critical path stays short as slices are added.

A final carry flag reports the edge on which the whole counter will roll over from all ones to zero. A synchronous active-high reset clears the count.

Top module: `cascade_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `count` becomes zero after that edge, whatever `cnt_en_n` is.
- R2: When `cnt_en_n` is high (1 = hold) at a rising edge, `count` keeps its value after that edge.
- R3: When `cnt_en_n` is low (0 = count) at a rising edge, `count` becomes its previous value plus one, modulo 2^(SLICE_W*NUM_SLICES).
- R4: The bits of `count` above the lowest slice (bit SLICE_W and up) change only on an enabled edge where the lowest slice, `count[SLICE_W-1:0]`, is all ones.
- R5: On an enabled edge where the lowest slice is all ones, that slice becomes zero. More generally, every slice below the highest slice that changes becomes zero.
- R6: `carry_out` is high (combinationally) exactly when `cnt_en_n` is low and `count` is all ones. After that edge, `count` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en_n | input | 1 | Global count enable, active low (0 = count, 1 = hold) |
| count | output | SLICE_W*NUM_SLICES | Current count value; slice k occupies bits [k*SLICE_W +: SLICE_W] |
| carry_out | output | 1 | High when the counter is enabled and all ones, so it wraps on the next edge |

## Verification
The bound checker watches the whole count on every cycle. It checks the reset clear, holding while disabled, the plus-one step while enabled, and that the upper slices stay frozen unless the lowest slice is saturated. It also checks the lowest slice's rollover and that a raised carry is followed by a zero count. The directed scenarios are what show the multi-slice carries at the real slice boundaries: 0xFF to 0x100 and 0xFFFF to 0x10000 on the default 32-bit build. A second, narrow build (two 4-bit slices) shows a full rollover of the counter. Those scenarios also show that the carry is blocked while the counter is held at its maximum.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int unsigned CC_SLICE_W = 8;
  localparam int unsigned CC_SLICES  = 4;

  function automatic int unsigned cc_total_w(input int unsigned sw, input int unsigned ns);
    return sw * ns;
  endfunction
endpackage

// File: rtl/cc_slice.sv
module cc_slice #(
  parameter int unsigned SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_n,
  output logic [SW-1:0] val,
  output logic          sat_n
);
  localparam logic [SW-1:0] STEP = SW'(1);

  always_ff @(posedge clk) begin
    if (rst)         val <= '0;
    else if (!adv_n) val <= val + STEP;
  end

  // low exactly while the slice holds all ones
  assign sat_n = ~(&val);
endmodule

// File: rtl/cc_enable_tree.sv
module cc_enable_tree #(
  parameter int unsigned NS = 4
) (
  input  logic          g_en_n,
  input  logic [NS-1:0] sat_n,
  output logic [NS:0]   adv_n
);
  // Entry NS is the enable a slice above the top would see: the wrap carry.
  for (genvar i = 0; i <= NS; i++) begin : g_term
    if (i == 0) begin : g_base
      assign adv_n[i] = g_en_n;
    end else begin : g_or
      assign adv_n[i] = g_en_n | (|sat_n[i-1:0]);
    end
  end
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int unsigned SLICE_W    = cc_pkg::CC_SLICE_W,
  parameter int unsigned NUM_SLICES = cc_pkg::CC_SLICES,
  localparam int unsigned W         = cc_pkg::cc_total_w(SLICE_W, NUM_SLICES)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en_n,
  output logic [W-1:0] count,
  output logic         carry_out
);
  logic [NUM_SLICES-1:0] sat_n;
  logic [NUM_SLICES:0]   adv_n;

  cc_enable_tree #(.NS(NUM_SLICES)) u_tree (
    .g_en_n (cnt_en_n),
    .sat_n  (sat_n),
    .adv_n  (adv_n)
  );

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    logic [SLICE_W-1:0] v;
    cc_slice #(.SW(SLICE_W)) u_slice (
      .clk   (clk),
      .rst   (rst),
      .adv_n (adv_n[k]),
      .val   (v),
      .sat_n (sat_n[k])
    );
    assign count[k*SLICE_W +: SLICE_W] = v;
  end

  assign carry_out = ~adv_n[NUM_SLICES];
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_en_n,
  input logic [W-1:0] count,
  input logic         carry_out
);
  localparam logic [W-1:0] ONE = W'(1);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> count == '0); // R1
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    cnt_en_n |=> $stable(count)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    !cnt_en_n |=> count == $past(count) + ONE); // R3
  AST_LOW_ROLL: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en_n && (&count[SW-1:0])) |=> count[SW-1:0] == '0); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    carry_out |=> count == '0); // R6

  if (W > SW) begin : g_upper
    AST_UPPER_FROZEN: assert property (@(posedge clk) disable iff (rst)
      !(&count[SW-1:0]) |=> $stable(count[W-1:SW])); // R4
  end
endmodule

bind cascade_counter cascade_counter_chk #(.W(W), .SW(SLICE_W)) u_chk (
  .clk(clk), .rst(rst), .cnt_en_n(cnt_en_n), .count(count), .carry_out(carry_out)
);

// File: tb/tb_cascade_counter.sv
`timescale 1ns/1ps
module tb_cascade_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_b_n = 1'b1;
  logic en_s_n = 1'b1;
  logic [31:0] count_b;
  logic [7:0]  count_s;
  logic carry_b, carry_s;
  logic [31:0] exp_b = '0;
  logic [7:0]  exp_s = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cascade_counter dut (
    .clk(clk), .rst(rst), .cnt_en_n(en_b_n), .count(count_b), .carry_out(carry_b)
  );

  cascade_counter #(.SLICE_W(4), .NUM_SLICES(2)) dut_s (
    .clk(clk), .rst(rst), .cnt_en_n(en_s_n), .count(count_s), .carry_out(carry_s)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  // starts and ends at a falling edge
  task automatic step_b(input logic v, input string req);
    en_b_n = v;
    #1;
    chk(carry_b === (!v && exp_b == 32'hFFFF_FFFF), "R6", longint'(carry_b),
        longint'(!v && exp_b == 32'hFFFF_FFFF));
    @(posedge clk);
    if (!v) exp_b = exp_b + 32'd1;
    @(negedge clk);
    chk(count_b === exp_b, req, longint'(count_b), longint'(exp_b));
  endtask

  task automatic step_s(input logic v, input string req);
    en_s_n = v;
    #1;
    chk(carry_s === (!v && exp_s == 8'hFF), "R6", longint'(carry_s),
        longint'(!v && exp_s == 8'hFF));
    @(posedge clk);
    if (!v) exp_s = exp_s + 8'd1;
    @(negedge clk);
    chk(count_s === exp_s, req, longint'(count_s), longint'(exp_s));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    en_b_n = 1'b0;
    en_s_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    exp_b = '0;
    exp_s = '0;
    chk(count_b === 32'd0, "R1", longint'(count_b), 0);
    chk(count_s === 8'd0, "R1", longint'(count_s), 0);
    rst = 1'b0;
    en_b_n = 1'b1;
    en_s_n = 1'b1;
  endtask

  task automatic t_count_basic();
    for (int i = 0; i < 20; i++) step_b(1'b0, "R3");
    chk(count_b === 32'd20, "R3", longint'(count_b), 20);
  endtask

  task automatic t_hold_pattern();
    for (int i = 0; i < 10; i++) step_b(1'b1, "R2");
    chk(count_b === 32'd20, "R2", longint'(count_b), 20);
    for (int i = 0; i < 20; i++) step_b(logic'(i % 3 == 0), (i % 3 == 0) ? "R2" : "R3");
  endtask

  task automatic t_cascade();
    while (exp_b != 32'h0000_00FF) step_b(1'b0, "R3");
    // held at the slice boundary: nothing may move
    step_b(1'b1, "R2");
    step_b(1'b0, "R5");
    chk(count_b === 32'h0000_0100, "R5", longint'(count_b), 32'h100);
    while (exp_b != 32'h0000_01FE) step_b(1'b0, "R3");
    step_b(1'b0, "R4");
    chk(count_b[31:8] === 24'h1, "R4", longint'(count_b[31:8]), 1);
    while (exp_b != 32'h0000_FFFF) step_b(1'b0, "R3");
    step_b(1'b0, "R5");
    chk(count_b === 32'h0001_0000, "R5", longint'(count_b), 32'h10000);
    step_b(1'b0, "R4");
    chk(count_b[31:8] === 24'h100, "R4", longint'(count_b[31:8]), 32'h100);
  endtask

  task automatic t_wrap_small();
    while (exp_s != 8'h0F) step_s(1'b0, "R3");
    step_s(1'b0, "R5");
    chk(count_s === 8'h10, "R5", longint'(count_s), 8'h10);
    while (exp_s != 8'hFF) step_s(1'b0, "R3");
    step_s(1'b1, "R6");
    chk(count_s === 8'hFF, "R6", longint'(count_s), 8'hFF);
    step_s(1'b0, "R6");
    chk(count_s === 8'h00, "R6", longint'(count_s), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_count_basic();
    t_hold_pattern();
    t_cascade();
    t_reset();
    t_wrap_small();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule